// File: doc/BRIEF.md
# Goal Node Evaluator

This block performs one processing turn for a single node of a goal hierarchy. A scheduler sends it the node's stored state record and, in the same beat, the per-alternative activation conditions, the static description of each alternative and the result codes currently reported by the node's children. The block returns the updated record, which the scheduler writes back. It also returns a vector of activation requests for the children. Success or failure flows upward: the parent reads the status field of the returned record.

A goal has up to `N_ALT` alternative decompositions. Each one is a primitive operation, a serial decomposition or a parallel decomposition. A primitive finishes through an external done/ok strobe. A serial decomposition drives its children one after another. A parallel decomposition drives all of its children together. On activation the node picks the lowest-numbered alternative whose condition holds. While running, the node fails as soon as the condition of the chosen alternative drops.

Both data interfaces use valid/ready. An input beat is accepted on a rising edge where `in_valid` and `in_ready` are both high, and `in_ready` is `!out_valid || out_ready`. The result is registered. It stays on the output with every field unchanged until `out_ready` takes it. A new beat can enter in the same cycle the previous result leaves, so one node is evaluated per cycle when there is no back-pressure.

Top module: `goal_node_eval`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: An IDLE record (status 0) with `in_start`=1 and at least one condition bit set becomes ACTIVE (status 1). The alternative field holds the lowest index whose `in_cond` bit is 1, and the child field is 0.
- R3: An IDLE record with `in_start`=1 and all condition bits clear becomes FAILED (status 3), with alternative 0, child 0 and no activation requests.
- R4: An ACTIVE record whose selected alternative's `in_cond` bit is 0 becomes FAILED. It keeps its alternative and child fields and asserts no activation requests, whatever the children report.
- R5: In a serial alternative (kind code 1), only the current child's request bit is set. When that child reports SUCCEEDED (code 2) and it is not the last child, the child field advances by one and the request moves to the next bit. While the child reports IDLE or ACTIVE, the record keeps the same child and request.
- R6: A serial alternative becomes SUCCEEDED when its last child (index `in_last` for that alternative) reports SUCCEEDED. It becomes FAILED when the current child reports FAILED (code 3), without advancing. Both results drop all requests.
- R7: A parallel alternative (kind code 2) requests children 0 through its last index at once, both on selection and while running. It becomes SUCCEEDED only when all of those children report SUCCEEDED, and FAILED when any of them reports FAILED. Children above the last index are ignored.
- R8: A primitive alternative (kind code 0; code 3 is treated the same) requests no children. It stays ACTIVE until `in_prim_done` is 1, then becomes SUCCEEDED if `in_prim_ok` is 1 and FAILED otherwise.
- R9: SUCCEEDED and FAILED records, and IDLE records with `in_start`=0, are returned unchanged with no requests. `in_start` has no effect on them.
- R10: The result of an accepted beat appears with `out_valid` one cycle after acceptance. It is held stable while `out_valid`=1 and `out_ready`=0, and `in_ready` equals `!out_valid || out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be taken |
| in_start | input | 1 | Parent activates this goal |
| in_status | input | 2 | Stored status: 0 IDLE, 1 ACTIVE, 2 SUCCEEDED, 3 FAILED |
| in_alt | input | AW (2) | Stored selected alternative |
| in_child | input | CW (3) | Stored current child index |
| in_cond | input | N_ALT (4) | Activation condition per alternative |
| in_kind | input | 2*N_ALT (8) | Kind per alternative, alternative 0 in the low bits |
| in_last | input | CW*N_ALT (12) | Last child index per alternative |
| in_prim_done | input | 1 | Primitive operation finished |
| in_prim_ok | input | 1 | Primitive operation succeeded |
| in_child_res | input | 2*N_CHILD (16) | Child status codes, child 0 in the low bits |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken |
| out_status | output | 2 | Updated status |
| out_alt | output | AW (2) | Updated alternative |
| out_child | output | CW (3) | Updated child index |
| out_act | output | N_CHILD (8) | Child activation requests |

## Verification
Every result is due exactly one clock after the rising edge that accepts its beat. The driver records the expected record in a queue at that acceptance edge. The monitor samples on falling edges and pops one entry on each falling edge where `out_valid` and `out_ready` are both high. The same sequence of cases runs twice: once with `out_ready` held high, and once with `out_ready` toggled in a fixed pattern. The toggled pass checks that a result under back-pressure does not change between consecutive falling edges, and that results still leave in order.

// File: rtl/gde_pkg.sv
package gde_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_OK     = 2'd2,
    ST_FAIL   = 2'd3
  } node_st_t;

  typedef enum logic [1:0] {
    K_PRIM = 2'd0,
    K_SER  = 2'd1,
    K_PAR  = 2'd2,
    K_RSV  = 2'd3
  } alt_kind_t;
endpackage

// File: rtl/gde_first_true.sv
module gde_first_true #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  always_comb begin
    if (found === 1'b1) begin
      a_pick_is_set_r2: assert (vec[idx] === 1'b1);
    end
  end
endmodule

// File: rtl/gde_eval.sv
module gde_eval
  import gde_pkg::*;
#(
  parameter int N_ALT   = 4,
  parameter int N_CHILD = 8,
  localparam int AW = $clog2(N_ALT),
  localparam int CW = $clog2(N_CHILD)
) (
  input  logic                  start,
  input  node_st_t              st,
  input  logic [AW-1:0]         alt,
  input  logic [CW-1:0]         child,
  input  logic [N_ALT-1:0]      cond,
  input  logic [2*N_ALT-1:0]    kind_v,
  input  logic [CW*N_ALT-1:0]   last_v,
  input  logic                  prim_done,
  input  logic                  prim_ok,
  input  logic [2*N_CHILD-1:0]  res_v,
  output node_st_t              nst,
  output logic [AW-1:0]         nalt,
  output logic [CW-1:0]         nchild,
  output logic [N_CHILD-1:0]    nact
);
  logic          any_cond;
  logic [AW-1:0] pick;

  gde_first_true #(.N(N_ALT)) u_pick (
    .vec  (cond),
    .found(any_cond),
    .idx  (pick)
  );

  // The alternative in use: the one being picked when starting, else the stored one.
  logic [AW-1:0]      use_alt;
  alt_kind_t          kind;
  logic [CW-1:0]      last;
  logic [N_CHILD-1:0] in_range;
  logic               any_fail, all_ok;
  node_st_t           cur_res;
  localparam logic [N_CHILD-1:0] ONE = N_CHILD'(1);

  always_comb begin
    use_alt = (st == ST_IDLE) ? pick : alt;
    kind    = alt_kind_t'(kind_v[2*use_alt +: 2]);
    last    = last_v[CW*use_alt +: CW];
    cur_res = node_st_t'(res_v[2*child +: 2]);
    any_fail = 1'b0;
    all_ok   = 1'b1;
    for (int i = 0; i < N_CHILD; i++) begin
      in_range[i] = (CW'(i) <= last);
      if (in_range[i]) begin
        if (res_v[2*i +: 2] == ST_FAIL) any_fail = 1'b1;
        if (res_v[2*i +: 2] != ST_OK)   all_ok   = 1'b0;
      end
    end
  end

  always_comb begin
    nst    = st;
    nalt   = alt;
    nchild = child;
    nact   = '0;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          nchild = '0;
          if (!any_cond) begin
            nst  = ST_FAIL;
            nalt = '0;
          end else begin
            nst  = ST_ACTIVE;
            nalt = pick;
            case (kind)
              K_SER:   nact = ONE;
              K_PAR:   nact = in_range;
              default: nact = '0;
            endcase
          end
        end
      end
      ST_ACTIVE: begin
        if (!cond[alt]) begin
          nst = ST_FAIL;
        end else begin
          case (kind)
            K_SER: begin
              if (cur_res == ST_FAIL) begin
                nst = ST_FAIL;
              end else if (cur_res == ST_OK) begin
                if (child == last) begin
                  nst = ST_OK;
                end else begin
                  nchild = child + 1'b1;
                  nact   = ONE << nchild;
                end
              end else begin
                nact = ONE << child;
              end
            end
            K_PAR: begin
              if (any_fail)    nst = ST_FAIL;
              else if (all_ok) nst = ST_OK;
              else             nact = in_range;
            end
            default: begin
              if (prim_done) nst = prim_ok ? ST_OK : ST_FAIL;
            end
          endcase
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/gde_out_reg.sv
module gde_out_reg
  import gde_pkg::*;
#(
  parameter int AW = 2,
  parameter int CW = 3,
  parameter int NC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          out_ready,
  input  node_st_t      d_st,
  input  logic [AW-1:0] d_alt,
  input  logic [CW-1:0] d_child,
  input  logic [NC-1:0] d_act,
  output logic          out_valid,
  output node_st_t      q_st,
  output logic [AW-1:0] q_alt,
  output logic [CW-1:0] q_child,
  output logic [NC-1:0] q_act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q_st      <= ST_IDLE;
      q_alt     <= '0;
      q_child   <= '0;
      q_act     <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      q_st      <= d_st;
      q_alt     <= d_alt;
      q_child   <= d_child;
      q_act     <= d_act;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(q_st) && $stable(q_alt) && $stable(q_child) && $stable(q_act)));

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (q_st == ST_OK || q_st == ST_FAIL)) |-> (q_act == '0));
endmodule

// File: rtl/goal_node_eval.sv
module goal_node_eval
  import gde_pkg::*;
#(
  parameter int N_ALT   = 4,
  parameter int N_CHILD = 8,
  localparam int AW = $clog2(N_ALT),
  localparam int CW = $clog2(N_CHILD)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_start,
  input  logic [1:0]           in_status,
  input  logic [AW-1:0]        in_alt,
  input  logic [CW-1:0]        in_child,
  input  logic [N_ALT-1:0]     in_cond,
  input  logic [2*N_ALT-1:0]   in_kind,
  input  logic [CW*N_ALT-1:0]  in_last,
  input  logic                 in_prim_done,
  input  logic                 in_prim_ok,
  input  logic [2*N_CHILD-1:0] in_child_res,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [1:0]           out_status,
  output logic [AW-1:0]        out_alt,
  output logic [CW-1:0]        out_child,
  output logic [N_CHILD-1:0]   out_act
);
  node_st_t           n_st, q_st;
  logic [AW-1:0]      n_alt;
  logic [CW-1:0]      n_child;
  logic [N_CHILD-1:0] n_act;
  logic               take;

  assign in_ready   = !out_valid || out_ready;
  assign take       = in_valid && in_ready;
  assign out_status = q_st;

  gde_eval #(.N_ALT(N_ALT), .N_CHILD(N_CHILD)) u_eval (
    .start    (in_start),
    .st       (node_st_t'(in_status)),
    .alt      (in_alt),
    .child    (in_child),
    .cond     (in_cond),
    .kind_v   (in_kind),
    .last_v   (in_last),
    .prim_done(in_prim_done),
    .prim_ok  (in_prim_ok),
    .res_v    (in_child_res),
    .nst      (n_st),
    .nalt     (n_alt),
    .nchild   (n_child),
    .nact     (n_act)
  );

  gde_out_reg #(.AW(AW), .CW(CW), .NC(N_CHILD)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .out_ready(out_ready),
    .d_st     (n_st),
    .d_alt    (n_alt),
    .d_child  (n_child),
    .d_act    (n_act),
    .out_valid(out_valid),
    .q_st     (q_st),
    .q_alt    (out_alt),
    .q_child  (out_child),
    .q_act    (out_act)
  );

  p_cond_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_status == ST_ACTIVE && !in_cond[in_alt]) |=>
      (out_valid && out_status == ST_FAIL && out_act == '0));

  p_serial_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_status == ST_ACTIVE && in_cond[in_alt] &&
     in_kind[2*in_alt +: 2] == K_SER) |=> $onehot0(out_act));

  p_nocond_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_status == ST_IDLE && in_start && in_cond == '0) |=>
      (out_status == ST_FAIL && out_act == '0));
endmodule

// File: tb/tb_goal_node_eval.sv
module tb_goal_node_eval;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        in_valid = 0, in_start = 0, in_prim_done = 0, in_prim_ok = 0;
  logic [1:0]  in_status = 0, in_alt = 0;
  logic [2:0]  in_child = 0;
  logic [3:0]  in_cond = 0;
  logic [7:0]  in_kind = {2'd1, 2'd2, 2'd1, 2'd0};
  logic [11:0] in_last = {3'd0, 3'd3, 3'd2, 3'd0};
  logic [15:0] in_child_res = 0;
  logic        in_ready, out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_status, out_alt;
  logic [2:0]  out_child;
  logic [7:0]  out_act;

  goal_node_eval dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_start(in_start), .in_status(in_status), .in_alt(in_alt), .in_child(in_child),
    .in_cond(in_cond), .in_kind(in_kind), .in_last(in_last),
    .in_prim_done(in_prim_done), .in_prim_ok(in_prim_ok), .in_child_res(in_child_res),
    .out_valid(out_valid), .out_ready(out_ready), .out_status(out_status),
    .out_alt(out_alt), .out_child(out_child), .out_act(out_act)
  );

  typedef struct packed {
    logic [1:0] st;
    logic [1:0] alt;
    logic [2:0] ch;
    logic [7:0] act;
  } rec_t;

  rec_t  exp_q[$];
  string tag_q[$];
  int    checks = 0, errors = 0;
  logic  bp_en = 0;
  int    cyc = 0;
  logic  finished = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 out_ready <= bp_en ? (cyc[0] ^ cyc[2]) : 1'b1;
  end

  // Monitor: compares popped expectations and checks holding under back-pressure.
  logic hold_prev = 0;
  rec_t prev_rec;
  always @(negedge clk) begin
    rec_t got;
    got = '{out_status, out_alt, out_child, out_act};
    if (rst_n) begin
      if (hold_prev) begin
        checks++;
        if (!out_valid || got !== prev_rec) begin
          errors++;
          $display("FAIL R10 held result changed: got %h expected %h", got, prev_rec);
        end
      end
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected result %h expected none", got);
        end else begin
          rec_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (got !== e) begin
            errors++;
            $display("FAIL %s got %h expected %h", t, got, e);
          end
        end
      end
      hold_prev = out_valid && !out_ready;
      prev_rec  = got;
    end
  end

  task automatic send(input logic st_start, input logic [1:0] st, input logic [1:0] alt,
                      input logic [2:0] ch, input logic [3:0] cond, input logic pd,
                      input logic po, input logic [15:0] res, input rec_t e,
                      input string tag);
    @(negedge clk);
    in_valid = 1; in_start = st_start; in_status = st; in_alt = alt; in_child = ch;
    in_cond = cond; in_prim_done = pd; in_prim_ok = po; in_child_res = res;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic run_all();
    // alt0 primitive, alt1 serial last 2, alt2 parallel last 3, alt3 serial last 0
    send(1, 0, 0, 0, 4'b0110, 0, 0, 16'h0,    '{2'd1, 2'd1, 3'd0, 8'h01}, "R2 pick lowest serial");
    send(1, 0, 3, 5, 4'b0000, 0, 0, 16'h0,    '{2'd3, 2'd0, 3'd0, 8'h00}, "R3 no condition");
    send(1, 0, 0, 0, 4'b1100, 0, 0, 16'h0,    '{2'd1, 2'd2, 3'd0, 8'h0F}, "R7 parallel start");
    send(1, 0, 0, 0, 4'b1111, 0, 0, 16'h0,    '{2'd1, 2'd0, 3'd0, 8'h00}, "R8 primitive start");
    send(0, 1, 1, 0, 4'b1101, 0, 0, 16'h0002, '{2'd3, 2'd1, 3'd0, 8'h00}, "R4 condition dropped");
    send(0, 1, 1, 0, 4'b0010, 0, 0, 16'h0001, '{2'd1, 2'd1, 3'd0, 8'h01}, "R5 serial wait");
    send(0, 1, 1, 0, 4'b0010, 0, 0, 16'h0002, '{2'd1, 2'd1, 3'd1, 8'h02}, "R5 serial advance");
    send(0, 1, 1, 2, 4'b0010, 0, 0, 16'h0020, '{2'd2, 2'd1, 3'd2, 8'h00}, "R6 serial last ok");
    send(0, 1, 1, 1, 4'b0010, 0, 0, 16'h000E, '{2'd3, 2'd1, 3'd1, 8'h00}, "R6 serial child fail");
    send(0, 1, 2, 0, 4'b0100, 0, 0, 16'hFF9A, '{2'd1, 2'd2, 3'd0, 8'h0F}, "R7 parallel running");
    send(0, 1, 2, 0, 4'b0100, 0, 0, 16'hFFAA, '{2'd2, 2'd2, 3'd0, 8'h00}, "R7 parallel all ok");
    send(0, 1, 2, 0, 4'b0100, 0, 0, 16'h00BA, '{2'd3, 2'd2, 3'd0, 8'h00}, "R7 parallel one fail");
    send(0, 1, 0, 0, 4'b0001, 0, 1, 16'h0,    '{2'd1, 2'd0, 3'd0, 8'h00}, "R8 primitive pending");
    send(0, 1, 0, 0, 4'b0001, 1, 1, 16'h0,    '{2'd2, 2'd0, 3'd0, 8'h00}, "R8 primitive ok");
    send(0, 1, 0, 0, 4'b0001, 1, 0, 16'h0,    '{2'd3, 2'd0, 3'd0, 8'h00}, "R8 primitive fail");
    send(1, 2, 3, 4, 4'b1111, 1, 1, 16'hFFFF, '{2'd2, 2'd3, 3'd4, 8'h00}, "R9 succeeded held");
    send(1, 3, 1, 6, 4'b1111, 0, 0, 16'h0,    '{2'd3, 2'd1, 3'd6, 8'h00}, "R9 failed held");
    send(0, 0, 2, 5, 4'b1111, 0, 0, 16'h0,    '{2'd0, 2'd2, 3'd5, 8'h00}, "R9 idle no start");
    send(0, 1, 3, 0, 4'b1000, 0, 0, 16'h0002, '{2'd2, 2'd3, 3'd0, 8'h00}, "R6 one-child serial ok");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: out_valid %b in_ready %b expected 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    run_all();
    repeat (4) @(posedge clk);
    bp_en = 1;
    run_all();
    bp_en = 0;
    repeat (10) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 results missing: got %0d left expected 0", exp_q.size());
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired: got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule